// File: doc/BRIEF.md
# Serial ADC Host Frame Controller

This block runs one conversion frame on a four-wire serial ADC link: an active-low select, a serial clock, a host-to-converter data line and a converter-to-host data line. It also watches the converter's busy line. A one-cycle start request lowers select. The block then shifts out a command byte, most significant bit first. The first bit of that byte is always a 1, which the converter treats as its start marker. The block keeps clocking until the frame holds a fixed number of serial clocks. It collects the conversion result, raises select again and reports the result with a one-cycle done pulse.

Whenever select is high, the serial clock and the host data line rest at 0. This stops the converter's start-bit search from firing on a stale high level. The host data line changes only on falling serial clock edges, so each bit is held for half a period after the converter samples it on the rising edge. Whatever the converter drives while the command byte goes out is thrown away. Result bits are taken only after busy has been seen high and then low again. A programmable half-period divider, latched at the start of each frame, sets the serial clock rate.

Top module: `adc_frame_host`

## Requirements
- R1: While `cs_n_o` is high, both `sclk_o` and `sdi_o` are 0.
- R2: Each frame has exactly FRAME_CLKS (default 24) rising `sclk_o` edges between the falling and the rising edge of `cs_n_o`. No rising edge occurs while `cs_n_o` is high.
- R3: The first CMD_BITS rising edges of a frame carry the command byte, MSB first. The first bit is always 1, whatever `cmd_i[CMD_BITS-1]` holds. Bits `cmd_i[CMD_BITS-2:0]` follow in descending order.
- R4: `sdi_o` changes only in the system cycle in which `sclk_o` falls, or when the frame begins. It is stable for the whole high phase. After the last command bit it is 0 until select rises.
- R5: Every high and low phase of `sclk_o` lasts `div_i`+1 system cycles. `div_i` is sampled when a start is accepted, and later changes have no effect on that frame.
- R6: `sdo_i` is ignored until `busy_i` has been seen high and then low, both at or after the CMD_BITS-th falling edge. The result is the `sdo_i` values sampled at the next RES_BITS falling edges, first sample in the MSB. If no busy pulse arrives, the result is 0.
- R7: `done_o` is high for exactly one cycle, the cycle in which `cs_n_o` rises. `result_o` takes the new value in that same cycle and holds it until the next `done_o`.
- R8: A start request is ignored while a frame or the inter-frame gap is in progress. Select stays high for at least 2×GAP_CLKS half periods between frames.
- R9: After reset, `cs_n_o` is 1, `sclk_o`, `sdi_o` and `done_o` are 0, and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a frame (accepted only when idle) |
| cmd_i | input | CMD_BITS | Command byte; its MSB is replaced by the start bit |
| div_i | input | DIV_W | Half-period length minus one, in system cycles |
| busy_i | input | 1 | Converter busy line |
| sdo_i | input | 1 | Converter serial data output |
| cs_n_o | output | 1 | Active-low select |
| sclk_o | output | 1 | Serial clock |
| sdi_o | output | 1 | Serial data to the converter |
| done_o | output | 1 | One-cycle frame-complete pulse |
| result_o | output | RES_BITS | Last captured conversion result |

## Verification
The assertions assume that `busy_i` and `sdo_i` change only in response to `sclk_o` edges. They also assume `busy_i` pulses at most once per frame, starting at or after the last command clock. The bench meets this with a behavioural converter model. The model changes `sdo_i` only on rising serial edges and raises busy at the 8th falling edge. It drops busy at the 9th falling edge and presents the result on rising edges 10 to 21. To show that the early window is discarded, the model puts deliberate garbage on `sdo_i` during the command byte.

// File: rtl/adc_frame_pkg.sv
`timescale 1ns/1ps
package adc_frame_pkg;
   typedef enum logic [2:0] {
      FR_IDLE,
      FR_LEAD,
      FR_HIGH,
      FR_LOW,
      FR_GAP
   } frame_state_e;
endpackage

// File: rtl/adc_half_timer.sv
`timescale 1ns/1ps
// Half-period tick generator; the length is latched on restart.
module adc_half_timer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);
   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] cnt_q;

   assign tick_o = run_i && (cnt_q == div_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         cnt_q <= '0;
      end else if (restart_i) begin
         div_q <= div_i;
         cnt_q <= '0;
      end else if (run_i) begin
         cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/adc_cmd_shifter.sv
`timescale 1ns/1ps
// Command shifter; the leading bit is forced to the start marker.
module adc_cmd_shifter #(
   parameter int CMD_BITS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_i,
   input  logic [CMD_BITS-1:0] cmd_i,
   input  logic                shift_i,
   output logic                bit_o
);
   localparam logic [CMD_BITS-1:0] START_MASK = {1'b1, {(CMD_BITS-1){1'b0}}};

   logic [CMD_BITS-1:0] sh_q;

   assign bit_o = sh_q[CMD_BITS-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (load_i) begin
         sh_q <= cmd_i | START_MASK;
      end else if (shift_i) begin
         sh_q <= {sh_q[CMD_BITS-2:0], 1'b0};
      end
   end
endmodule

// File: rtl/adc_result_capture.sv
`timescale 1ns/1ps
// Busy-pulse gated result collector.
module adc_result_capture #(
   parameter int RES_BITS    = 12,
   parameter int SYNC_STAGES = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear_i,
   input  logic                busy_i,
   input  logic                window_i,
   input  logic                sample_i,
   input  logic                sdo_i,
   output logic [RES_BITS-1:0] data_o
);
   localparam int BITS_W = $clog2(RES_BITS + 1);

   logic              busy_s;
   logic              busy_d;
   logic              seen_q;
   logic              armed_q;
   logic [BITS_W-1:0] bits_q;
   logic [RES_BITS-1:0] data_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign busy_s = busy_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= (sync_q << 1) | SYNC_STAGES'(busy_i);
         end
         assign busy_s = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   assign data_o = data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_d  <= 1'b0;
         seen_q  <= 1'b0;
         armed_q <= 1'b0;
         bits_q  <= '0;
         data_q  <= '0;
      end else if (clear_i) begin
         busy_d  <= 1'b0;
         seen_q  <= 1'b0;
         armed_q <= 1'b0;
         bits_q  <= '0;
         data_q  <= '0;
      end else begin
         busy_d <= busy_s;
         if (window_i && busy_s)
            seen_q <= 1'b1;
         if (window_i && seen_q && busy_d && !busy_s)
            armed_q <= 1'b1;
         if (sample_i && armed_q && (bits_q != BITS_W'(RES_BITS))) begin
            data_q <= {data_q[RES_BITS-2:0], sdo_i};
            bits_q <= bits_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/adc_frame_host.sv
`timescale 1ns/1ps
module adc_frame_host #(
   parameter int DIV_W       = 8,
   parameter int CMD_BITS    = 8,
   parameter int RES_BITS    = 12,
   parameter int FRAME_CLKS  = 24,
   parameter int GAP_CLKS    = 1,
   parameter int SYNC_STAGES = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [CMD_BITS-1:0] cmd_i,
   input  logic [DIV_W-1:0]    div_i,
   input  logic                busy_i,
   input  logic                sdo_i,
   output logic                cs_n_o,
   output logic                sclk_o,
   output logic                sdi_o,
   output logic                done_o,
   output logic [RES_BITS-1:0] result_o
);
   import adc_frame_pkg::*;

   localparam int CNT_W      = $clog2(FRAME_CLKS + 1);
   localparam int GAP_HALVES = 2 * GAP_CLKS;
   localparam int GAP_W      = $clog2(GAP_HALVES + 1);

   generate
      if (FRAME_CLKS < CMD_BITS + RES_BITS + 1) begin : g_bad_frame
         $error("frame too short for command, busy slot and result");
      end
      if (CMD_BITS < 2) begin : g_bad_cmd
         $error("command needs a start bit and at least one payload bit");
      end
      if (GAP_CLKS < 1 || DIV_W < 1 || RES_BITS < 2) begin : g_bad_misc
         $error("gap, divider and result widths must be positive");
      end
   endgenerate

   frame_state_e        state_q;
   logic [CNT_W-1:0]    clk_cnt_q;
   logic [GAP_W-1:0]    gap_q;
   logic                cs_n_q;
   logic                sclk_q;
   logic                done_q;
   logic [RES_BITS-1:0] result_q;
   logic [RES_BITS-1:0] cap_data;
   logic                tick;
   logic                accept;
   logic                fall_edge;

   assign accept    = (state_q == FR_IDLE) && start_i;
   assign fall_edge = (state_q == FR_HIGH) && tick;

   adc_half_timer #(.DIV_W(DIV_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (accept),
      .run_i     (state_q != FR_IDLE),
      .div_i     (div_i),
      .tick_o    (tick)
   );

   adc_cmd_shifter #(.CMD_BITS(CMD_BITS)) u_cmd (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (accept),
      .cmd_i   (cmd_i),
      .shift_i (fall_edge),
      .bit_o   (sdi_o)
   );

   adc_result_capture #(.RES_BITS(RES_BITS), .SYNC_STAGES(SYNC_STAGES)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (accept),
      .busy_i   (busy_i),
      .window_i (clk_cnt_q >= CNT_W'(CMD_BITS)),
      .sample_i (fall_edge),
      .sdo_i    (sdo_i),
      .data_o   (cap_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= FR_IDLE;
         clk_cnt_q <= '0;
         gap_q     <= '0;
         cs_n_q    <= 1'b1;
         sclk_q    <= 1'b0;
         done_q    <= 1'b0;
         result_q  <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            FR_IDLE: begin
               if (start_i) begin
                  state_q   <= FR_LEAD;
                  cs_n_q    <= 1'b0;
                  clk_cnt_q <= '0;
               end
            end
            FR_LEAD: begin
               if (tick) begin
                  state_q <= FR_HIGH;
                  sclk_q  <= 1'b1;
               end
            end
            FR_HIGH: begin
               if (tick) begin
                  state_q   <= FR_LOW;
                  sclk_q    <= 1'b0;
                  clk_cnt_q <= clk_cnt_q + 1'b1;
               end
            end
            FR_LOW: begin
               if (tick) begin
                  if (clk_cnt_q == CNT_W'(FRAME_CLKS)) begin
                     state_q  <= FR_GAP;
                     cs_n_q   <= 1'b1;
                     done_q   <= 1'b1;
                     result_q <= cap_data;
                     gap_q    <= '0;
                  end else begin
                     state_q <= FR_HIGH;
                     sclk_q  <= 1'b1;
                  end
               end
            end
            FR_GAP: begin
               if (tick) begin
                  if (gap_q == GAP_W'(GAP_HALVES - 1)) state_q <= FR_IDLE;
                  else                                 gap_q   <= gap_q + 1'b1;
               end
            end
            default: state_q <= FR_IDLE;
         endcase
      end
   end

   assign cs_n_o   = cs_n_q;
   assign sclk_o   = sclk_q;
   assign done_o   = done_q;
   assign result_o = result_q;
endmodule

// File: rtl/adc_frame_host_chk.sv
`timescale 1ns/1ps
module adc_frame_host_chk #(
   parameter int FRAME_CLKS = 24,
   parameter int RES_BITS   = 12
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cs_n_o,
   input logic                sclk_o,
   input logic                sdi_o,
   input logic                done_o,
   input logic [RES_BITS-1:0] result_o
);
   logic [15:0] rise_cnt;
   logic [15:0] hi_cnt;
   logic        sclk_d;
   logic        ended;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_cnt <= '0;
         hi_cnt   <= '0;
         sclk_d   <= 1'b0;
         ended    <= 1'b0;
      end else begin
         sclk_d <= sclk_o;
         if (cs_n_o)                  rise_cnt <= '0;
         else if (sclk_o && !sclk_d)  rise_cnt <= rise_cnt + 1'b1;
         if (!cs_n_o)                 hi_cnt <= '0;
         else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
         if (done_o)                  ended <= 1'b1;
      end
   end

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> (!sclk_o && !sdi_o));
   assert_frame_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n_o) |-> (rise_cnt == 16'(FRAME_CLKS)));
   assert_sclk_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk_o) |-> !cs_n_o);
   assert_sdi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_o && $past(sclk_o)) |-> $stable(sdi_o));
   assert_sdi_low_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n_o) |-> $past(!sdi_o));
   assert_done_at_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $rose(cs_n_o));
   assert_rise_gives_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n_o) |-> done_o);
   assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(result_o));
   assert_gap_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cs_n_o) && ended) |-> (hi_cnt >= 16'd2));
endmodule

bind adc_frame_host adc_frame_host_chk #(
   .FRAME_CLKS (FRAME_CLKS),
   .RES_BITS   (RES_BITS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_n_o   (cs_n_o),
   .sclk_o   (sclk_o),
   .sdi_o    (sdi_o),
   .done_o   (done_o),
   .result_o (result_o)
);

// File: tb/test_adc_frame_host.sv
`timescale 1ns/1ps
module test_adc_frame_host;
   localparam int DIV_W = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [7:0]  cmd_i = '0;
   logic [DIV_W-1:0] div_i = '0;
   logic        busy_i, sdo_i, cs_n_o, sclk_o, sdi_o, done_o;
   logic [11:0] result_o;

   always #2.5 clk = ~clk;

   adc_frame_host #(.DIV_W(DIV_W), .CMD_BITS(8), .RES_BITS(12), .FRAME_CLKS(24),
                    .GAP_CLKS(1), .SYNC_STAGES(0)) i_adc_frame_host (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i), .div_i(div_i),
      .busy_i(busy_i), .sdo_i(sdo_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
      .sdi_o(sdi_o), .done_o(done_o), .result_o(result_o));

   int tests = 0;
   int fails = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // converter model
   int         m_rise = 0, m_fall = 0, m_frames = 0, m_last_rises = 0;
   logic [7:0] m_cmd = '0, m_junk = '0;
   logic [11:0] m_val = '0;
   bit         m_skip = 1'b0;
   logic       busy_r = 1'b0, sdo_r = 1'b0;
   assign busy_i = busy_r;
   assign sdo_i  = sdo_r;

   always @(negedge cs_n_o) begin
      m_rise = 0; m_fall = 0; m_frames++; busy_r <= 1'b0;
   end
   always @(posedge cs_n_o) m_last_rises = m_rise;
   always @(posedge sclk_o) if (cs_n_o === 1'b0) begin
      m_rise++;
      if (m_rise <= 8) m_cmd = {m_cmd[6:0], sdi_o};
      if (m_rise >= 10 && m_rise <= 21) sdo_r <= m_val[21-m_rise];
      else if (m_rise <= 8)             sdo_r <= m_junk[m_rise-1];
      else                              sdo_r <= 1'b0;
   end
   always @(negedge sclk_o) if (cs_n_o === 1'b0) begin
      m_fall++;
      if (m_fall == 8 && !m_skip) busy_r <= 1'b1;
      if (m_fall == 9)            busy_r <= 1'b0;
   end

   // port monitor
   int idle_viol = 0, hold_viol = 0, end_viol = 0, done_cnt = 0, done_bad = 0;
   int hr = 0, hr_min = 999, hr_max = 0, cs_hi = 0, last_gap = 0;
   logic p_sclk = 1'b0, p_sdi = 1'b0, p_cs = 1'b1;

   always @(negedge clk) if (rst_n) begin
      if (cs_n_o && (sclk_o || sdi_o)) idle_viol++;
      if (sclk_o && p_sclk && (sdi_o !== p_sdi)) hold_viol++;
      if (cs_n_o && !p_cs && p_sdi) end_viol++;
      if (sclk_o) hr++;
      else if (p_sclk) begin
         if (hr < hr_min) hr_min = hr;
         if (hr > hr_max) hr_max = hr;
         hr = 0;
      end
      if (done_o) begin
         done_cnt++;
         if (!(cs_n_o && !p_cs)) done_bad++;
      end
      if (cs_n_o) cs_hi++;
      else if (p_cs) begin last_gap = cs_hi; cs_hi = 0; end
      p_sclk = sclk_o; p_sdi = sdi_o; p_cs = cs_n_o;
   end

   task automatic clear_mon();
      idle_viol = 0; hold_viol = 0; end_viol = 0; done_cnt = 0; done_bad = 0;
      hr_min = 999; hr_max = 0;
   endtask

   task automatic wait_done();
      int n = 0;
      while (!done_o && n < 3000) begin @(negedge clk); n++; end
      if (n >= 3000) chk(1'b0, "R7 done timeout", n, 0);
   endtask

   task automatic run_frame(input logic [7:0] cmd, input logic [11:0] val, input int dv,
                            input bit skip, input logic [7:0] junk);
      m_val = val; m_skip = skip; m_junk = junk; cmd_i = cmd; div_i = DIV_W'(dv);
      @(negedge clk);
      clear_mon();
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      wait_done();
      @(negedge clk);
   endtask

   task automatic settle(input int dv);
      repeat (2 * (dv + 1) + 3) @(negedge clk);
   endtask

   function automatic logic [11:0] pat(input int k);
      if (k < 12)       return 12'(1) << k;
      else if (k == 12) return 12'h000;
      else if (k == 13) return 12'hFFF;
      else if (k == 14) return 12'hA5A;
      else              return 12'h5A5;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [7:0] c;
      logic [11:0] r1;
      int f0;
      repeat (5) @(negedge clk);
      chk(cs_n_o === 1'b1, "R9 reset select", int'(cs_n_o), 1);
      chk(sclk_o === 1'b0 && sdi_o === 1'b0, "R9 reset clock/data", int'({sclk_o, sdi_o}), 0);
      chk(done_o === 1'b0, "R9 reset done", int'(done_o), 0);
      chk(result_o === 12'h000, "R9 reset result", int'(result_o), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // sweep of divider values and data patterns
      for (int dv = 0; dv < 4; dv++) begin
         for (int k = 0; k < 16; k++) begin
            c = 8'(k * 37 + dv * 11);
            run_frame(c, pat(k), dv, 1'b0, ~c);
            chk(m_cmd == {1'b1, c[6:0]}, "R3 command byte", int'(m_cmd), int'({1'b1, c[6:0]}));
            chk(result_o == pat(k), "R6 result", int'(result_o), int'(pat(k)));
            chk(m_last_rises == 24, "R2 clocks per frame", m_last_rises, 24);
            chk(hr_min == dv + 1 && hr_max == dv + 1, "R5 half period", hr_max, dv + 1);
            chk(done_cnt == 1 && done_bad == 0, "R7 done pulse", done_cnt, 1);
            chk(idle_viol == 0, "R1 idle lines", idle_viol, 0);
            chk(hold_viol == 0 && end_viol == 0, "R4 data hold", hold_viol + end_viol, 0);
            settle(dv);
         end
      end

      // R6: no busy pulse, garbage early -> result 0
      run_frame(8'hA0, 12'hFFF, 1, 1'b1, 8'hFF);
      chk(result_o == 12'h000, "R6 missing busy", int'(result_o), 0);
      settle(1);

      // R5: divider change during a frame has no effect
      m_val = 12'h123; m_skip = 1'b0; cmd_i = 8'h9C; div_i = 4'd1;
      @(negedge clk); clear_mon(); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      repeat (3) @(negedge clk);
      div_i = 4'd7;
      wait_done(); @(negedge clk);
      chk(hr_min == 2 && hr_max == 2, "R5 divider latched", hr_max, 2);
      chk(result_o == 12'h123, "R6 result after divider change", int'(result_o), 'h123);
      settle(7);

      // R8: start ignored mid-frame and during the gap
      f0 = m_frames;
      m_val = 12'h3C9; cmd_i = 8'hC3; div_i = 4'd2;
      @(negedge clk); clear_mon(); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      repeat (10) @(negedge clk);
      cmd_i = 8'h11; start_i = 1'b1;
      repeat (3) @(negedge clk);
      start_i = 1'b0;
      wait_done();
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (20) @(negedge clk);
      chk(m_frames == f0 + 1, "R8 starts ignored", m_frames - f0, 1);
      chk(m_cmd == 8'hC3, "R8 first command kept", int'(m_cmd), 'hC3);
      chk(cs_n_o === 1'b1, "R8 no frame from gap start", int'(cs_n_o), 1);

      // R8/R7: back-to-back frames, gap length and result hold
      m_val = 12'h3C9; cmd_i = 8'h85; div_i = 4'd2;
      start_i = 1'b1;
      wait_done();
      r1 = result_o;
      @(negedge clk);
      m_val = 12'h0F0;
      repeat (15) @(negedge clk);
      chk(cs_n_o === 1'b0, "R8 second frame started", int'(cs_n_o), 0);
      chk(result_o == r1 && r1 == 12'h3C9, "R7 result held", int'(result_o), 'h3C9);
      wait_done();
      start_i = 1'b0;
      @(negedge clk);
      chk(result_o == 12'h0F0, "R7 second result", int'(result_o), 'h0F0);
      chk(last_gap >= 6, "R8 select high gap", last_gap, 6);
      settle(2);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule